// File: doc/BRIEF.md
# SDRAM Single-Access Sequencer with Per-Bank Row Tracking

This block sits between a simple host port and the command pins of an SDR SDRAM. Each host request is one read or one write of a single location, with byte enables. The sequencer keeps a record of which row, if any, is open in each bank. A request to the open row of its bank goes straight to the column command. A request to a closed bank first opens the row. A request to a different row of an open bank first closes that bank, then opens the new row. The gaps between these commands come from configuration inputs, counted in clock cycles.

The host address is laid out as `{bank, row, column}`. Stepping past the last column of a row therefore lands on the next row of the same bank, and the sequencer handles that step as a page break: it closes the old row and opens the new one before the access. Initialization, refresh and low-power entry are handled elsewhere. The data bus is 32 bits wide. A configuration bit can narrow it to the low 16 bits by masking the upper two lanes.

States: `S_IDLE` (waiting), `S_PRE` (precharge, held until the bank's timers allow it), `S_ACT` (activate), `S_GAP` (counting out tRP or tRCD), `S_COL` (read or write command), `S_CL1` and `S_CL2` (CAS latency), `S_RDY` (read data returned). Transitions: IDLE→COL on a row hit, IDLE→ACT on a closed bank, IDLE→PRE on a row miss; PRE→ACT or PRE→GAP once precharge is issued; ACT→COL or ACT→GAP; GAP→ACT or GAP→COL when its count expires; COL→IDLE after a write; COL→CL1→CL2→RDY→IDLE after a read.

Top module: `sdram_seq`

## Requirements
- R1: After reset, every bank is closed, the pins carry NOP, `host_ready` is low, all four mask lines are high and the data bus is not driven.
- R2: Commands are encoded on (cs_n, ras_n, cas_n, we_n) as NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010; no other encoding appears.
- R3: A request that is high in cycle k while the sequencer is idle, and that targets the open row of its bank, produces its column command in cycle k+1 with no PRECHARGE or ACTIVE.
- R4: A request to a closed bank produces ACTIVE in cycle k+1 and the column command tRCD cycles after ACTIVE.
- R5: A request to another row of an open bank produces PRECHARGE, then ACTIVE tRP cycles later, then the column command tRCD cycles after ACTIVE.
- R6: PRECHARGE to a bank is issued no earlier than tRAS cycles after that bank's ACTIVE, no earlier than tWR cycles after its last WRITE, and otherwise in cycle k+1.
- R7: A request to column 0 of row r+1 after an access to the last column of row r in the same bank is handled as a page break (PRECHARGE, ACTIVE of row r+1, column command).
- R8: Read data is sampled from the bus two cycles after READ and returned on `host_rdata` with `host_ready` in the third cycle after READ.
- R9: During WRITE the data bus is driven with the write data and `host_ready` is high in that same cycle; the bus is driven in no other cycle.
- R10: `host_ready` is high for exactly one cycle per request.
- R11: During the column command each mask line is the inverse of its byte enable (bit i covers byte i, so bit 3 covers bits 31:24); with the narrow-bus bit set, mask bits 3 and 2 are forced high; outside column and latency cycles all masks are high.
- R12: ACTIVE carries the row on the address pins; the column command carries the column on address bits 0 and up with bit 10 low; PRECHARGE has address bit 10 low; the bank pins carry the bank on all three.
- R13: Opening a row in one bank leaves the open rows of the other banks in place, so a later request to them is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the SDRAM |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_narrow | input | 1 | 1 selects a 16-bit data bus (upper lanes masked) |
| cfg_trp | input | 4 | Precharge-to-activate gap, cycles (1..15) |
| cfg_trcd | input | 4 | Activate-to-column gap, cycles (1..15) |
| cfg_tras | input | 4 | Minimum activate-to-precharge, cycles (1..15) |
| cfg_twr | input | 4 | Minimum write-to-precharge, cycles (1..15) |
| host_req | input | 1 | Request; held until `host_ready` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 24 | Word address {bank, row, column} |
| host_be | input | 4 | Byte enables, bit i = byte i |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | One-cycle completion strobe |
| host_rdata | output | 32 | Read data, valid with `host_ready` after a read |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Multiplexed row / column address |
| sd_dqm | output | 4 | Byte masks, high = lane masked |
| sd_dq_o | output | 32 | Write data to the bus |
| sd_dq_oe | output | 1 | Bus output enable |
| sd_dq_i | input | 32 | Read data from the bus |

## Verification
Every result is tied to the cycle k in which the request is first high: a hit gives its column command at k+1, a closed bank gives ACTIVE at k+1 and the column command at k+1+tRCD, and a miss gives PRECHARGE at the later of k+1, last ACTIVE+tRAS and last WRITE+tWR, then ACTIVE after tRP and the column command after tRCD. Write completion is due in the column-command cycle and read completion three cycles after READ. The bench drives inputs just after the falling edge and records every pin command together with the cycle number at the falling edge, then compares the recorded cycle numbers with these sums computed from its own bank model, sweeping tRP and tRCD over 1 to 3 and two tRAS/tWR pairs.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE
    } sd_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_ACT,
        S_GAP,
        S_COL,
        S_CL1,
        S_CL2,
        S_RDY
    } seq_state_e;

endpackage

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
    parameter int ROW_W = 13,
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             wr_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [CFG_W-1:0] tras_i,
    input  logic [CFG_W-1:0] twr_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             pre_ok_o
);

    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [CFG_W-1:0] ras_cnt;
    logic [CFG_W-1:0] wr_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            row_q   <= '0;
            ras_cnt <= '0;
            wr_cnt  <= '0;
        end else begin
            if (act_i) begin
                open_q <= 1'b1;
                row_q  <= row_i;
            end else if (pre_i) begin
                open_q <= 1'b0;
            end

            if (act_i)
                ras_cnt <= (tras_i == '0) ? '0 : tras_i - CFG_W'(1);
            else if (ras_cnt != '0)
                ras_cnt <= ras_cnt - CFG_W'(1);

            if (wr_i)
                wr_cnt <= (twr_i == '0) ? '0 : twr_i - CFG_W'(1);
            else if (wr_cnt != '0)
                wr_cnt <= wr_cnt - CFG_W'(1);
        end
    end

    assign open_o   = open_q;
    assign row_o    = row_q;
    assign pre_ok_o = (ras_cnt == '0) && (wr_cnt == '0);

    // R4: a bank is only activated while it is closed
    a_r4_act_closed: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> !open_q);

    // R5: a bank is only precharged while it is open
    a_r5_pre_open: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> open_q);

    // R6: precharge waits for both the tRAS and tWR windows
    a_r6_pre_window: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> (ras_cnt == '0 && wr_cnt == '0));

    // R6: a write is only issued to an open bank, so tWR always starts inside an open window
    a_r6_write_open: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> open_q);

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
    parameter int NBANK = 4,
    parameter int ROW_W = 13,
    parameter int CFG_W = 4,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        act_i,
    input  logic                        pre_i,
    input  logic                        wr_i,
    input  logic [BANK_W-1:0]           bank_i,
    input  logic [ROW_W-1:0]            row_i,
    input  logic [CFG_W-1:0]            tras_i,
    input  logic [CFG_W-1:0]            twr_i,
    output logic [NBANK-1:0]            open_o,
    output logic [NBANK-1:0][ROW_W-1:0] row_o,
    output logic [NBANK-1:0]            pre_ok_o
);

    for (genvar g = 0; g < NBANK; g++) begin : g_slot
        logic sel;
        assign sel = (bank_i == BANK_W'(g));

        sdram_bank_slot #(
            .ROW_W (ROW_W),
            .CFG_W (CFG_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (act_i && sel),
            .pre_i    (pre_i && sel),
            .wr_i     (wr_i && sel),
            .row_i    (row_i),
            .tras_i   (tras_i),
            .twr_i    (twr_i),
            .open_o   (open_o[g]),
            .row_o    (row_o[g]),
            .pre_ok_o (pre_ok_o[g])
        );
    end

    // R13: at most one bank changes state per cycle
    a_r13_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({act_i, pre_i}) <= 1);

endmodule

// File: rtl/sdram_cmd_pins.sv
module sdram_cmd_pins
    import sdram_seq_pkg::*;
(
    input  sd_cmd_e cmd_i,
    output logic    cs_n,
    output logic    ras_n,
    output logic    cas_n,
    output logic    we_n
);

    always_comb begin
        unique case (cmd_i)
            CMD_ACT: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            CMD_RD:  {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            CMD_WR:  {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            CMD_PRE: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
    end

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
    import sdram_seq_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int DATA_W = 32,
    parameter int CFG_W  = 4,
    localparam int BANK_W = $clog2(NBANK),
    localparam int ADDR_W = BANK_W + ROW_W + COL_W,
    localparam int MASK_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_narrow,
    input  logic [CFG_W-1:0]  cfg_trp,
    input  logic [CFG_W-1:0]  cfg_trcd,
    input  logic [CFG_W-1:0]  cfg_tras,
    input  logic [CFG_W-1:0]  cfg_twr,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [MASK_W-1:0] host_be,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_a,
    output logic [MASK_W-1:0] sd_dqm,
    output logic [DATA_W-1:0] sd_dq_o,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_i
);

    localparam int A10 = 10;

    // column to address pins: bit 10 is skipped, it carries the precharge flag
    function automatic logic [ROW_W-1:0] col_to_pins(input logic [COL_W-1:0] c);
        logic [ROW_W-1:0] a;
        a = '0;
        for (int i = 0; i < COL_W; i++) begin
            if (i < A10) a[i] = c[i];
            else         a[i + 1] = c[i];
        end
        return a;
    endfunction

    // request fields
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    assign req_bank = host_addr[ADDR_W-1 -: BANK_W];
    assign req_row  = host_addr[COL_W +: ROW_W];
    assign req_col  = host_addr[COL_W-1:0];

    // latched request
    logic [BANK_W-1:0] q_bank;
    logic [ROW_W-1:0]  q_row;
    logic [COL_W-1:0]  q_col;
    logic              q_we;
    logic [MASK_W-1:0] q_be;
    logic [DATA_W-1:0] q_wdata;
    logic [DATA_W-1:0] rd_q;

    seq_state_e        state_q, state_d;
    seq_state_e        gap_tgt;
    logic [CFG_W-1:0]  gap_cnt;

    logic [NBANK-1:0]            bank_open;
    logic [NBANK-1:0][ROW_W-1:0] bank_row;
    logic [NBANK-1:0]            bank_pre_ok;

    logic req_hit, req_closed;
    assign req_closed = !bank_open[req_bank];
    assign req_hit    = bank_open[req_bank] && (bank_row[req_bank] == req_row);

    logic fire_act, fire_pre, fire_wr;
    assign fire_act = (state_q == S_ACT);
    assign fire_pre = (state_q == S_PRE) && bank_pre_ok[q_bank];
    assign fire_wr  = (state_q == S_COL) && q_we;

    sdram_bank_tracker #(
        .NBANK (NBANK),
        .ROW_W (ROW_W),
        .CFG_W (CFG_W)
    ) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (fire_act),
        .pre_i    (fire_pre),
        .wr_i     (fire_wr),
        .bank_i   (q_bank),
        .row_i    (q_row),
        .tras_i   (cfg_tras),
        .twr_i    (cfg_twr),
        .open_o   (bank_open),
        .row_o    (bank_row),
        .pre_ok_o (bank_pre_ok)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (host_req) begin
                    if (req_hit)         state_d = S_COL;
                    else if (req_closed) state_d = S_ACT;
                    else                 state_d = S_PRE;
                end
            end
            S_PRE: begin
                if (bank_pre_ok[q_bank])
                    state_d = (cfg_trp <= CFG_W'(1)) ? S_ACT : S_GAP;
            end
            S_ACT:  state_d = (cfg_trcd <= CFG_W'(1)) ? S_COL : S_GAP;
            S_GAP:  if (gap_cnt == '0) state_d = gap_tgt;
            S_COL:  state_d = q_we ? S_IDLE : S_CL1;
            S_CL1:  state_d = S_CL2;
            S_CL2:  state_d = S_RDY;
            S_RDY:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // gap counter, request latch and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            gap_tgt <= S_IDLE;
            q_bank  <= '0;
            q_row   <= '0;
            q_col   <= '0;
            q_we    <= 1'b0;
            q_be    <= '0;
            q_wdata <= '0;
            rd_q    <= '0;
        end else begin
            if (state_q == S_IDLE && host_req) begin
                q_bank  <= req_bank;
                q_row   <= req_row;
                q_col   <= req_col;
                q_we    <= host_we;
                q_be    <= host_be;
                q_wdata <= host_wdata;
            end
            if (fire_pre) begin
                gap_cnt <= cfg_trp - CFG_W'(2);
                gap_tgt <= S_ACT;
            end else if (fire_act) begin
                gap_cnt <= cfg_trcd - CFG_W'(2);
                gap_tgt <= S_COL;
            end else if (state_q == S_GAP && gap_cnt != '0) begin
                gap_cnt <= gap_cnt - CFG_W'(1);
            end
            if (state_q == S_CL2)
                rd_q <= sd_dq_i;
        end
    end

    // outputs
    sd_cmd_e           cmd;
    logic [MASK_W-1:0] lane_mask;

    always_comb begin
        lane_mask = ~q_be;
        if (cfg_narrow)
            lane_mask[MASK_W-1 -: MASK_W/2] = '1;
    end

    always_comb begin
        cmd        = CMD_NOP;
        sd_a       = '0;
        sd_dqm     = '1;
        sd_dq_o    = '0;
        sd_dq_oe   = 1'b0;
        host_ready = 1'b0;
        unique case (state_q)
            S_PRE: if (bank_pre_ok[q_bank]) cmd = CMD_PRE;
            S_ACT: begin
                cmd  = CMD_ACT;
                sd_a = q_row;
            end
            S_COL: begin
                sd_a   = col_to_pins(q_col);
                sd_dqm = lane_mask;
                if (q_we) begin
                    cmd        = CMD_WR;
                    sd_dq_o    = q_wdata;
                    sd_dq_oe   = 1'b1;
                    host_ready = 1'b1;
                end else begin
                    cmd = CMD_RD;
                end
            end
            S_CL1, S_CL2: sd_dqm = lane_mask;
            S_RDY:  host_ready = 1'b1;
            default: ;
        endcase
    end

    assign sd_ba      = q_bank;
    assign host_rdata = rd_q;

    sdram_cmd_pins u_pins (
        .cmd_i (cmd),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n)
    );

    // R10: ready never stays high two cycles in a row
    a_r10_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    // R9: the bus is driven only while the pins encode WRITE
    a_r9_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (!sd_cs_n && sd_ras_n && !sd_cas_n && !sd_we_n));

    // R12: a column command only goes to the open row it was meant for
    a_r12_col_open: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COL) |-> (bank_open[q_bank] && bank_row[q_bank] == q_row));

    // R8: read completion is three cycles after the READ command
    a_r8_read_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RDY) |-> ($past(state_q, 3) == S_COL && !q_we));

    // R12: precharge is single-bank
    a_r12_pre_a10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n) |-> !sd_a[A10]);

endmodule

// File: tb/sdram_seq_bench.sv
`timescale 1ns/1ps
module sdram_seq_bench;

    localparam int AW = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_narrow = 1'b0;
    logic [3:0]  cfg_trp = 4'd2, cfg_trcd = 4'd2, cfg_tras = 4'd3, cfg_twr = 4'd2;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_a;
    logic [3:0]  sd_dqm;
    logic [31:0] sd_dq_o;
    logic        sd_dq_oe;
    logic [31:0] sd_dq_i = '0;

    always #2 clk = ~clk;

    sdram_seq u_sdram_seq (
        .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow),
        .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_twr(cfg_twr),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_be(host_be), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
        .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] init_word(input int a);
        return 32'h5A00_0000 ^ a;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] en);
        logic [31:0] r;
        r = old;
        for (int i = 0; i < 4; i++)
            if (en[i]) r[8*i +: 8] = nw[8*i +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- SDRAM pin model and recorder ----------------
    logic [31:0] sdmem [int];
    logic [12:0] mdl_row [4];
    logic [31:0] pend1 = '0, pend2 = '0;

    int n_pre, n_act, n_col, n_bad, n_rdy;
    int pre_cyc, act_cyc, col_cyc, rdy_cyc;
    int pre_ba, act_ba, col_ba, pre_a10, act_row, col_a;
    int col_dqm, col_oe, col_isw;
    logic [31:0] col_dq, rdy_data;

    always @(negedge clk) begin
        int key;
        sd_dq_i = pend2;
        pend2   = pend1;
        pend1   = '0;
        // R2 encodings: NOP 0111, ACT 0011, READ 0101, WRITE 0100, PRE 0010
        case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
            4'b0111: ;
            4'b0010: begin n_pre++; pre_cyc = cyc; pre_ba = sd_ba; pre_a10 = sd_a[10]; end
            4'b0011: begin n_act++; act_cyc = cyc; act_ba = sd_ba; act_row = sd_a;
                           mdl_row[sd_ba] = sd_a; end
            4'b0101, 4'b0100: begin
                n_col++; col_cyc = cyc; col_ba = sd_ba; col_a = sd_a;
                col_dqm = sd_dqm; col_oe = sd_dq_oe; col_dq = sd_dq_o;
                col_isw = !sd_we_n ? 1 : 0;
                key = {sd_ba, mdl_row[sd_ba], sd_a[8:0]};
                if (!sdmem.exists(key)) sdmem[key] = init_word(key);
                if (col_isw != 0) sdmem[key] = merge(sdmem[key], sd_dq_o, ~sd_dqm);
                else              pend1 = sdmem[key];
            end
            default: n_bad++;
        endcase
        if (host_ready) begin n_rdy++; rdy_cyc = cyc; rdy_data = host_rdata; end
    end

    // ---------------- bench reference model ----------------
    logic [31:0] ref_mem [int];
    bit          m_open [4];
    int          m_row [4];
    int          m_act [4];
    int          m_wr  [4];

    task automatic model_reset();
        for (int b = 0; b < 4; b++) begin
            m_open[b] = 0; m_row[b] = 0; m_act[b] = -1000; m_wr[b] = -1000;
        end
    endtask

    task automatic access(input int b, input int r, input int c, input bit we,
                          input logic [3:0] be, input logic [31:0] data);
        int k, pre, act, col, rdy, key, waited;
        bit hit, closed;
        logic [31:0] exp_rd;
        logic [3:0] exp_dqm;
        @(negedge clk); #1;
        k = cyc;
        n_pre = 0; n_act = 0; n_col = 0; n_bad = 0; n_rdy = 0;
        host_req = 1'b1; host_we = we; host_addr = {b[1:0], r[12:0], c[8:0]};
        host_be = be; host_wdata = data;

        hit    = m_open[b] && (m_row[b] == r);
        closed = !m_open[b];
        pre = -1; act = -1;
        if (hit) col = k + 1;
        else if (closed) begin act = k + 1; col = act + cfg_trcd; end
        else begin
            pre = k + 1;
            if (m_act[b] + cfg_tras > pre) pre = m_act[b] + cfg_tras;
            if (m_wr[b] + cfg_twr > pre)   pre = m_wr[b] + cfg_twr;
            act = pre + cfg_trp;
            col = act + cfg_trcd;
        end
        rdy = we ? col : col + 3;

        waited = 0;
        while (n_rdy == 0 && waited < 300) begin
            @(negedge clk); #1; waited++;
        end
        host_req = 1'b0;
        if (n_rdy == 0) begin
            errors++;
            $display("FAIL R10 no ready: actual 0 expected 1");
        end
        @(negedge clk); #1;

        key = {b[1:0], r[12:0], c[8:0]};
        if (!ref_mem.exists(key)) ref_mem[key] = init_word(key);
        exp_dqm = ~be | (cfg_narrow ? 4'b1100 : 4'b0000);
        exp_rd  = ref_mem[key];
        if (we) ref_mem[key] = merge(ref_mem[key], data, ~exp_dqm);

        chk("R2 unknown command count", n_bad, 0);
        chk("R3 column command cycle", col_cyc, col);
        chk("R3 column command count", n_col, 1);
        chk("R5 precharge count", n_pre, (!hit && !closed) ? 1 : 0);
        chk("R4 activate count", n_act, hit ? 0 : 1);
        if (!hit && !closed) begin
            chk("R6 precharge cycle", pre_cyc, pre);
            chk("R12 precharge bank", pre_ba, b);
            chk("R12 precharge a10", pre_a10, 0);
        end
        if (!hit) begin
            chk("R4 activate cycle", act_cyc, act);
            chk("R12 activate row", act_row, r);
            chk("R12 activate bank", act_ba, b);
        end
        chk("R12 column address", col_a, c);
        chk("R12 column bank", col_ba, b);
        chk("R11 column mask", col_dqm, exp_dqm);
        chk("R10 ready pulse count", n_rdy, 1);
        if (we) begin
            chk("R9 write ready cycle", rdy_cyc, rdy);
            chk("R9 write data", col_dq, data);
            chk("R9 write drive", col_oe, 1);
        end else begin
            chk("R8 read ready cycle", rdy_cyc, rdy);
            chk("R8 read data", rdy_data, exp_rd);
            chk("R9 no drive on read", col_oe, 0);
        end

        m_open[b] = 1; m_row[b] = r;
        if (act >= 0) m_act[b] = act;
        if (we) m_wr[b] = col;
    endtask

    task automatic phase(input int trp, input int trcd, input int tras, input int twr,
                         input bit narrow);
        @(negedge clk); #1;
        rst_n = 1'b0;
        cfg_trp = trp[3:0]; cfg_trcd = trcd[3:0]; cfg_tras = tras[3:0]; cfg_twr = twr[3:0];
        cfg_narrow = narrow;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        model_reset();
        @(negedge clk); #1;
        // R1: reset state at the pins
        chk("R1 idle command", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk("R1 ready low", host_ready, 0);
        chk("R1 masks high", sd_dqm, 4'hF);
        chk("R1 bus released", sd_dq_oe, 0);

        access(0, 5, 10, 1, 4'hF, 32'hA1B2_C3D4);      // R4 closed bank
        access(0, 5, 10, 0, 4'hF, 0);                  // R3 hit, R8 read back
        access(0, 5, 511, 1, 4'b0011, 32'h1357_9BDF);  // R11 half-word write, last column
        access(0, 6, 0, 1, 4'hF, 32'h0F0F_F0F0);       // R7 page break into next row
        access(0, 5, 511, 0, 4'hF, 0);                 // R5/R6 miss right after a write
        access(1, 9, 3, 1, 4'b1000, 32'hDEAD_BEEF);    // R11 single byte, other bank
        access(0, 5, 10, 0, 4'hF, 0);                  // R13 bank 0 row survives
        access(1, 9, 3, 0, 4'hF, 0);                   // R13 bank 1 hit
        access(3, 8191, 7, 1, 4'b0110, 32'h2468_ACE0); // top row, middle lanes
        access(3, 8191, 7, 0, 4'hF, 0);
        access(3, 1, 7, 0, 4'hF, 0);                   // R6 read miss after write
    endtask

    initial begin
        for (int t = 0; t < 2; t++)
            for (int trp = 1; trp <= 3; trp++)
                for (int trcd = 1; trcd <= 3; trcd++)
                    phase(trp, trcd, t == 0 ? 3 : 6, t == 0 ? 2 : 5, trp == 2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #700000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule